// File: doc/BRIEF.md
# Hamming ECC Accumulator for 256-Byte Blocks

This block sits beside a NAND flash data port and watches every byte that moves through it, in either direction. While it is enabled it folds each byte into a running single-error-correcting, double-error-detecting Hamming code. The code covers one block of 256 bytes and is three bytes long. Software starts a block with a single control write that clears the code and enables accumulation. It moves the 256 bytes and then reads the three code bytes. To find and fix an error, software compares the code stored in flash with the one just computed. The block itself never corrects anything.

The code has six column-parity bits and sixteen line-parity bits. The column bits are taken over bit groups within each byte. The line bits are an even and an odd parity for each bit of the byte's index within the block. A control bit selects the inverted output convention, in which an erased block of all 0xFF bytes reads back as FF FF FF. The code can be read as three separate bytes. It can also be read as one 32-bit word with a status byte in the lowest lane and the code bytes in a fixed permuted order.

Top module: `hamm_ecc256`

## Requirements
- R1: After reset, the enable bit and the mode bit are 0, and all three code bytes read 0x00.
- R2: A control write stores wdata bit 0 as the enable bit and wdata bit 2 as the mode bit. Both read back on `ctl_q` as {mode, 0, enable}, so ctl_q[0] is the enable bit and ctl_q[2] is the mode bit. Bit 1, the clear bit, is never retained, so ctl_q[1] is always 0.
- R3: A control write with bit 1 set returns the byte index and every parity accumulator to zero from the next cycle on. If a data byte arrives in the same cycle as the clear, the byte is discarded.
- R4: While the enable bit is 0, data bytes leave the code unchanged.
- R5: Column parity bit j is the XOR, over all accepted bytes, of every data bit t for which bit (j/2) of t equals j mod 2. Column parity bit j appears in code byte 2 at bit j+2.
- R6: Line parity bit k is the XOR, over all accepted bytes whose index has bit (k/2) equal to k mod 2, of each byte's row parity. Bits k = 0..7 form code byte 0 and bits k = 8..15 form code byte 1, with the lowest k in the least significant bit.
- R7: With the mode bit set to 1, all 24 code bits are complemented. Bits 1:0 of code byte 2 therefore read 11 in mode 1 and 00 in mode 0, and a block of all 0xFF bytes reads FF FF FF in mode 1.
- R8: After 256 bytes have been accepted, further bytes leave the code unchanged until the next clear.
- R9: The packed word holds the status input in bits 7:0, code byte 1 in bits 15:8, code byte 0 in bits 23:16 and code byte 2 in bits 31:24.
- R10: A byte accepted at a clock edge is reflected in the code outputs right after that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control write data: bit 0 enable, bit 1 clear, bit 2 mode |
| ctl_q | output | 3 | Control readback {mode, 0, enable} |
| dat_vld | input | 1 | A data byte is passing the port this cycle |
| dat_byte | input | 8 | Data byte |
| stat_in | input | 8 | Status byte placed in the low lane of the packed word |
| code_b0 | output | 8 | Code byte 0 (line parity, low half) |
| code_b1 | output | 8 | Code byte 1 (line parity, high half) |
| code_b2 | output | 8 | Code byte 2 (column parity, bits 7:2) |
| code_word | output | 32 | Packed status and code word |

## Verification
Every accumulator is a single register stage. The code outputs and `ctl_q` therefore change exactly one clock edge after the byte or control write that causes them. The mode bit changes the outputs at that same edge, because the inversion is combinational on the registered parity. The bench drives inputs on falling edges and samples on the next falling edge. For a streamed block, it checks at the falling edge where `dat_vld` drops, by which time the last byte has been taken. The packed word is combinational from the code and `stat_in`, so it is compared in the same sample as the three code bytes.

// File: rtl/hecc_pkg.sv
package hecc_pkg;
  localparam int BYTE_W = 8;
  localparam int CP_W   = 6;

  // Column parity of one byte: bit j covers the data bits t whose bit (j/2) equals j%2.
  function automatic logic [CP_W-1:0] col_fold(input logic [BYTE_W-1:0] b);
    logic [CP_W-1:0] r;
    r[0] = b[0] ^ b[2] ^ b[4] ^ b[6];
    r[1] = b[1] ^ b[3] ^ b[5] ^ b[7];
    r[2] = b[0] ^ b[1] ^ b[4] ^ b[5];
    r[3] = b[2] ^ b[3] ^ b[6] ^ b[7];
    r[4] = ^b[3:0];
    r[5] = ^b[7:4];
    return r;
  endfunction

  // Odd-population flag of one byte, used as its row parity.
  function automatic logic row_par(input logic [BYTE_W-1:0] b);
    return ^b;
  endfunction
endpackage

// File: rtl/ecc_ctrl.sv
module ecc_ctrl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr,
  input  logic [7:0] wdata,
  output logic       en,
  output logic       mode,
  output logic       clr
);
  logic en_q, mode_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      mode_q <= 1'b0;
    end else if (wr) begin
      en_q   <= wdata[0];
      mode_q <= wdata[2];
    end
  end

  assign en   = en_q;
  assign mode = mode_q;
  assign clr  = wr & wdata[1];

  assert_ctl_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> (en == $past(wdata[0])) && (mode == $past(wdata[2])));
  assert_ctl_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(en) && $stable(mode));
endmodule

// File: rtl/ecc_parity_acc.sv
module ecc_parity_acc #(
  parameter int BLK_BYTES = 256
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 en,
  input  logic                 vld,
  input  logic [7:0]           dat,
  output logic [2*$clog2(BLK_BYTES)-1:0] lp,
  output logic [5:0]           cp,
  output logic                 full
);
  import hecc_pkg::*;
  localparam int IDX_W = $clog2(BLK_BYTES);
  localparam int LP_W  = 2 * IDX_W;

  logic [IDX_W:0]    idx;
  logic [LP_W-1:0]   lp_q;
  logic [CP_W-1:0]   cp_q;
  logic [LP_W-1:0]   line_hit;
  logic              take;
  logic              row;

  assign full = (idx == (IDX_W+1)'(BLK_BYTES));
  assign take = vld & en & ~full & ~clr;
  assign row  = row_par(dat);

  for (genvar b = 0; b < IDX_W; b++) begin : g_line
    assign line_hit[2*b]   = row & ~idx[b];
    assign line_hit[2*b+1] = row &  idx[b];
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      idx  <= '0;
      lp_q <= '0;
      cp_q <= '0;
    end else if (take) begin
      idx  <= idx + 1'b1;
      lp_q <= lp_q ^ line_hit;
      cp_q <= cp_q ^ col_fold(dat);
    end
  end

  assign lp = lp_q;
  assign cp = cp_q;

  assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (idx == '0) && (lp_q == '0) && (cp_q == '0));
  assert_hold_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !clr) |=> $stable(lp_q) && $stable(cp_q) && $stable(idx));
  assert_cap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !clr) |=> full && $stable(lp_q) && $stable(cp_q));
  assert_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> idx == $past(idx) + 1'b1);
endmodule

// File: rtl/ecc_code_fmt.sv
module ecc_code_fmt #(
  parameter int LP_W = 16
) (
  input  logic [LP_W-1:0] lp,
  input  logic [5:0]      cp,
  input  logic            inv,
  input  logic [7:0]      stat,
  output logic [7:0]      b0,
  output logic [7:0]      b1,
  output logic [7:0]      b2,
  output logic [31:0]     word
);
  localparam int RAW_W = LP_W + 8;
  logic [RAW_W-1:0] raw, code;

  assign raw  = {cp, 2'b00, lp};
  assign code = inv ? ~raw : raw;
  assign b0   = code[7:0];
  assign b1   = code[15:8];
  assign b2   = code[23:16];
  assign word = {b2, b0, b1, stat};
endmodule

// File: rtl/hamm_ecc256.sv
module hamm_ecc256 #(
  parameter int BLK_BYTES = 256
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ctl_wr,
  input  logic [7:0]  ctl_wdata,
  output logic [2:0]  ctl_q,
  input  logic        dat_vld,
  input  logic [7:0]  dat_byte,
  input  logic [7:0]  stat_in,
  output logic [7:0]  code_b0,
  output logic [7:0]  code_b1,
  output logic [7:0]  code_b2,
  output logic [31:0] code_word
);
  localparam int LP_W = 2 * $clog2(BLK_BYTES);

  logic            en, mode, clr, full;
  logic [LP_W-1:0] lp;
  logic [5:0]      cp;

  ecc_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr(ctl_wr), .wdata(ctl_wdata),
    .en(en), .mode(mode), .clr(clr)
  );

  ecc_parity_acc #(.BLK_BYTES(BLK_BYTES)) u_acc (
    .clk(clk), .rst_n(rst_n), .clr(clr), .en(en), .vld(dat_vld),
    .dat(dat_byte), .lp(lp), .cp(cp), .full(full)
  );

  ecc_code_fmt #(.LP_W(LP_W)) u_fmt (
    .lp(lp), .cp(cp), .inv(mode), .stat(stat_in),
    .b0(code_b0), .b1(code_b1), .b2(code_b2), .word(code_word)
  );

  assign ctl_q = {mode, 1'b0, en};

  assert_full_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !ctl_wr) |=> $stable(code_b0) && $stable(code_b1) && $stable(code_b2));
endmodule

// File: tb/hamm_ecc256_tb.sv
`timescale 1ns/1ps
module hamm_ecc256_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctl_wr = 1'b0;
  logic [7:0]  ctl_wdata = '0;
  logic [2:0]  ctl_q;
  logic        dat_vld = 1'b0;
  logic [7:0]  dat_byte = '0;
  logic [7:0]  stat_in = 8'h3C;
  logic [7:0]  code_b0, code_b1, code_b2;
  logic [31:0] code_word;

  int checks = 0;
  int fails  = 0;
  logic [7:0] blk [256];

  always #4 clk = ~clk;

  hamm_ecc256 dut_i (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .ctl_q(ctl_q),
    .dat_vld(dat_vld), .dat_byte(dat_byte), .stat_in(stat_in),
    .code_b0(code_b0), .code_b1(code_b1), .code_b2(code_b2), .code_word(code_word)
  );

  // {kind[1:0], mode, value[7:0], pos[7:0]}; kind 0 fill, 1 single byte, 2 index xor value
  localparam logic [18:0] VEC [6] = '{
    {2'd0, 1'b1, 8'hFF, 8'd0},
    {2'd0, 1'b0, 8'hA5, 8'd0},
    {2'd1, 1'b0, 8'h80, 8'd255},
    {2'd1, 1'b1, 8'h13, 8'd77},
    {2'd2, 1'b0, 8'h00, 8'd0},
    {2'd2, 1'b1, 8'h5A, 8'd0}
  };

  function automatic logic [23:0] model(input logic inv);
    logic [15:0] l;
    logic [5:0]  c;
    l = '0; c = '0;
    for (int k = 0; k < 16; k++)
      for (int i = 0; i < 256; i++)
        if (((i >> (k/2)) & 1) == (k % 2)) l[k] = l[k] ^ (^blk[i]);
    for (int j = 0; j < 6; j++)
      for (int i = 0; i < 256; i++)
        for (int t = 0; t < 8; t++)
          if (((t >> (j/2)) & 1) == (j % 2)) c[j] = c[j] ^ blk[i][t];
    return inv ? ~{c, 2'b00, l} : {c, 2'b00, l};
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr_ctl(input logic [7:0] v);
    @(negedge clk); ctl_wr = 1'b1; ctl_wdata = v;
    @(negedge clk); ctl_wr = 1'b0;
  endtask

  task automatic send_one(input logic [7:0] v);
    @(negedge clk); dat_vld = 1'b1; dat_byte = v;
    @(negedge clk); dat_vld = 1'b0;
  endtask

  task automatic send_blk();
    for (int i = 0; i < 256; i++) begin
      @(negedge clk); dat_vld = 1'b1; dat_byte = blk[i];
    end
    @(negedge clk); dat_vld = 1'b0;
  endtask

  task automatic chk_code(input string req, input logic [23:0] exp);
    chk(req, {8'h00, code_b2, code_b1, code_b0}, {8'h00, exp});
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog got=hung exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [23:0] e;
    logic [1:0] kind;
    logic md;
    logic [7:0] v, p;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ctl", {29'd0, ctl_q}, 32'd0);
    chk_code("R1 code", 24'h000000);

    // R2: 0x07 keeps enable and mode, drops clear
    wr_ctl(8'h07);
    chk("R2 ctl_q", {29'd0, ctl_q}, 32'd5);

    // table of blocks: R5 R6 R7 R9
    foreach (VEC[n]) begin
      {kind, md, v, p} = VEC[n];
      for (int i = 0; i < 256; i++)
        blk[i] = (kind == 2'd0) ? v : (kind == 2'd1) ? ((i == int'(p)) ? v : 8'h00) : (8'(i) ^ v);
      e = model(md);
      wr_ctl({5'd0, md, 2'b11});
      send_blk();
      chk_code("R5 R6 R7 block code", e);
      chk("R9 packed", code_word, {e[23:16], e[7:0], e[15:8], stat_in});
    end

    // R7: erased block in inverted mode reads FF FF FF
    for (int i = 0; i < 256; i++) blk[i] = 8'hFF;
    wr_ctl(8'h07);
    send_blk();
    chk_code("R7 erased", 24'hFFFFFF);

    // R8: extra byte after a full block has no effect
    send_one(8'h01);
    chk_code("R8 past 256", 24'hFFFFFF);

    // R10: single byte visible right after its edge; 0x01 at index 0 -> 55 55 54
    wr_ctl(8'h03);
    send_one(8'h01);
    chk_code("R10 one byte", 24'h545555);

    // R4: disabled bytes ignored (mode flips view only)
    wr_ctl(8'h04);
    chk_code("R4 view inverted", 24'hABAAAA);
    send_one(8'h37);
    send_one(8'hC1);
    chk_code("R4 disabled", 24'hABAAAA);
    chk("R2 ctl disabled", {29'd0, ctl_q}, 32'd4);

    // R3: clear wins over a same-cycle byte, then index restarts at 0
    wr_ctl(8'h01);
    send_one(8'h55);
    @(negedge clk); ctl_wr = 1'b1; ctl_wdata = 8'h03; dat_vld = 1'b1; dat_byte = 8'hFF;
    @(negedge clk); ctl_wr = 1'b0; dat_vld = 1'b0;
    chk_code("R3 cleared", 24'h000000);
    send_one(8'h01);
    chk_code("R3 index restart", 24'h545555);

    // R9 with a different status byte
    stat_in = 8'hE1;
    #1;
    chk("R9 status lane", code_word, 32'h545555E1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule